// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Detector

This block watches twenty-four input pins split into three groups of eight. A pin takes part in its group only when its own mask bit is set. Whenever an enabled pin moves from low to high or from high to low, the group's sticky flag is set. The flag stays set until software clears it. Each group has an interrupt request, which is the flag gated by a per-group enable bit. Each group also has a wake output. The wake output is formed without a clock, so it can bring a sleeping system back up while the I/O clock is stopped.

Each pin goes through a fixed path:

1. A level latch that is open while the clock is low.
2. A capture register.
3. A mask gate. A masked-off pin drives 0 through this gate.
4. A masked-input register.
5. A history register.

A change is the difference between the masked-input register and the history register. The path does not care which way the pin is driven, so writing a value to a pin configured as an output can raise a software interrupt. A small write and read register interface holds the masks and the enables, and it clears flags with write-one-to-clear.

Top module: `pcd_top`

## Requirements
- R1: After reset, `flag_o`, `irq_o` and `wake_o` are 0. Reading addresses 0, 1, 2, 3 and 4 returns 0.
- R2: Pin index n belongs to group n/8. A change on an enabled pin sets only the flag bit of that group.
- R3: A pin whose mask bit is 0 cannot set a flag, whatever it does.
- R4: A pin change that is stable while the clock is low before rising edge E1 leaves the flag at 0 after edges E1 and E2. The flag reads 1 after edge E3.
- R5: A rising change and a falling change on an enabled pin both set the flag.
- R6: A set flag stays set until a write to address 4 with a 1 in bit g clears flag g. Bits written as 0 leave their flags unchanged.
- R7: If a change sets flag g in the same cycle that a write clears it, the flag ends at 1.
- R8: `irq_o[g]` equals `flag_o[g]` AND bit g of the enable register at address 3.
- R9: Unmasking a pin that is low causes no event. Unmasking or masking a pin that is high counts as a change.
- R10: `wake_o[g]` rises with no clock edge once an enabled pin differs from its captured masked value. It returns to 0 after edge E2.
- R11: Addresses 0 to 2 hold the masks of groups 0 to 2, with bit k mapping to pin 8g+k. Address 3 bits 2:0 hold the enables and the upper bits read 0. Address 4 reads the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pin_i | input | 24 | Pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| flag_o | output | 3 | Sticky per-group change flags |
| irq_o | output | 3 | Per-group interrupt requests |
| wake_o | output | 3 | Clockless per-group wake indications |

## Verification
The properties assume that the pins only move while the clock is low, so that the level latch hands a settled value to the capture register. The bench drives every pin and every register write on the falling edge, so each stimulus sits in the latch's open phase and is stable well before the next rising edge. The properties also assume that the write strobe is a clean synchronous signal. The bench raises and lowers it only on falling edges.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    parameter int NUM_GRP = 3;
    parameter int GRP_W   = 8;
    parameter int ADDR_W  = 3;
    localparam int NUM_PINS = NUM_GRP * GRP_W;
    localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(NUM_GRP);
    localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(NUM_GRP + 1);

    typedef struct packed {
        logic [GRP_W-1:0] cap;
        logic [GRP_W-1:0] inp;
        logic [GRP_W-1:0] hist;
    } path_t;
endpackage

// File: rtl/pcd_pin_path.sv
module pcd_pin_path
    import pcd_pkg::*;
#(
    parameter int W = GRP_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] mask_i,
    output logic         change_o,
    output logic         wake_o
);
    typedef struct packed {
        logic [W-1:0] cap;
        logic [W-1:0] inp;
        logic [W-1:0] hist;
    } st_t;

    logic [W-1:0] lat_q;
    st_t st_d, st_q;

    // transparent while the clock is low, holds across the high phase
    always_latch begin
        if (!clk_i) begin
            lat_q <= pin_i;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.cap  = lat_q;
        st_d.inp  = st_q.cap & mask_i;
        st_d.hist = st_q.inp;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign change_o = |(st_q.inp ^ st_q.hist);
    // clockless path: raw masked pin against the last captured masked value
    assign wake_o   = |((pin_i & mask_i) ^ st_q.inp);
endmodule

// File: rtl/pcd_regs.sv
module pcd_regs
    import pcd_pkg::*;
#(
    parameter int G  = NUM_GRP,
    parameter int W  = GRP_W,
    parameter int AW = ADDR_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       wr_addr_i,
    input  logic [W-1:0]        wr_data_i,
    input  logic [AW-1:0]       rd_addr_i,
    input  logic [G-1:0]        flag_i,
    output logic [G-1:0][W-1:0] mask_o,
    output logic [G-1:0]        en_o,
    output logic [G-1:0]        clr_o,
    output logic [W-1:0]        rd_data_o
);
    localparam logic [AW-1:0] A_EN   = AW'(G);
    localparam logic [AW-1:0] A_FLAG = AW'(G + 1);

    typedef struct packed {
        logic [G-1:0][W-1:0] mask;
        logic [G-1:0]        en;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        clr_o = '0;
        if (wr_en_i) begin
            for (int g = 0; g < G; g++) begin
                if (wr_addr_i == AW'(g)) begin
                    r_d.mask[g] = wr_data_i;
                end
            end
            if (wr_addr_i == A_EN) begin
                r_d.en = wr_data_i[G-1:0];
            end
            if (wr_addr_i == A_FLAG) begin
                clr_o = wr_data_i[G-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int g = 0; g < G; g++) begin
            if (rd_addr_i == AW'(g)) begin
                rd_data_o = r_q.mask[g];
            end
        end
        if (rd_addr_i == A_EN) begin
            rd_data_o = W'(r_q.en);
        end
        if (rd_addr_i == A_FLAG) begin
            rd_data_o = W'(flag_i);
        end
    end

    assign mask_o = r_q.mask;
    assign en_o   = r_q.en;
endmodule

// File: rtl/pcd_flags.sv
module pcd_flags
    import pcd_pkg::*;
#(
    parameter int G = NUM_GRP
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [G-1:0] set_i,
    input  logic [G-1:0] clr_i,
    input  logic [G-1:0] en_i,
    output logic [G-1:0] flag_o,
    output logic [G-1:0] irq_o
);
    typedef struct packed {
        logic [G-1:0] flag;
    } fl_t;

    fl_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        for (int g = 0; g < G; g++) begin
            if (set_i[g]) begin
                f_d.flag[g] = 1'b1;       // set has priority over clear
            end else if (clr_i[g]) begin
                f_d.flag[g] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flag_o = f_q.flag;
    assign irq_o  = f_q.flag & en_i;
endmodule

// File: rtl/pcd_top.sv
module pcd_top
    import pcd_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [GRP_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [GRP_W-1:0]    rd_data_o,
    output logic [NUM_GRP-1:0]  flag_o,
    output logic [NUM_GRP-1:0]  irq_o,
    output logic [NUM_GRP-1:0]  wake_o
);
    logic [NUM_GRP-1:0][GRP_W-1:0] mask;
    logic [NUM_GRP-1:0]            en;
    logic [NUM_GRP-1:0]            clr;
    logic [NUM_GRP-1:0]            grp_change;

    pcd_regs #(.G(NUM_GRP), .W(GRP_W), .AW(ADDR_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .flag_i    (flag_o),
        .mask_o    (mask),
        .en_o      (en),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        pcd_pin_path #(.W(GRP_W)) u_path (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .pin_i    (pin_i[g*GRP_W +: GRP_W]),
            .mask_i   (mask[g]),
            .change_o (grp_change[g]),
            .wake_o   (wake_o[g])
        );
    end

    pcd_flags #(.G(NUM_GRP)) u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (grp_change),
        .clr_i  (clr),
        .en_i   (en),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker
    import pcd_pkg::*;
(
    input logic                clk_i,
    input logic                rst_ni,
    input logic                wr_en_i,
    input logic [ADDR_W-1:0]   wr_addr_i,
    input logic [GRP_W-1:0]    wr_data_i,
    input logic [NUM_GRP-1:0]  flag_o,
    input logic [NUM_GRP-1:0]  irq_o,
    input logic [NUM_GRP-1:0]  grp_change
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        logic clr_hit;
        assign clr_hit = wr_en_i && (wr_addr_i == ADDR_FLAG) && wr_data_i[g];

        assert_flag_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_o[g] && !clr_hit) |=> flag_o[g]);

        assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_hit && !grp_change[g]) |=> !flag_o[g]);

        assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            grp_change[g] |=> flag_o[g]);

        assert_no_spurious_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!flag_o[g] && !grp_change[g]) |=> !flag_o[g]);

        assert_irq_needs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[g] |-> flag_o[g]);
    end
endmodule

bind pcd_top pcd_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .grp_change (grp_change)
);

// File: tb/tb_pcd_top.sv
`timescale 1ns/1ps
module tb_pcd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pin = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [2:0]  flag, irq, wake;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pcd_top dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .flag_o(flag), .irq_o(irq), .wake_o(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #0.1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wake", wake, 0);
        for (int a = 0; a < 5; a++) rd("R1 read", 3'(a), 8'h00);

        // R11 register map
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        rd("R11 mask0", 3'd0, 8'hFF);
        rd("R11 mask1", 3'd1, 8'hFF);
        rd("R11 mask2", 3'd2, 8'hFF);
        rd("R11 en", 3'd3, 8'h07);

        // R2 R4 R5 R8 R10 sweep every pin, both directions
        for (int p = 0; p < 24; p++) begin
            for (int dir = 0; dir < 2; dir++) begin
                logic [2:0] expg;
                expg = 3'(1 << (p / 8));
                pin[p] = ~pin[p];
                #0.1;
                chk("R10 wake async", wake, expg);
                cyc();
                chk("R4 not after E1", flag, 0);
                cyc();
                chk("R4 not after E2", flag, 0);
                chk("R10 wake drops", wake, 0);
                cyc();
                chk(dir == 0 ? "R2 R5 rise sets group" : "R2 R5 fall sets group", flag, expg);
                chk("R8 irq follows flag", irq, expg);
                rd("R11 flag read", 3'd4, 8'(expg));
                wr(3'd4, 8'h07);
                chk("R6 clear", flag, 0);
            end
        end

        // R3 masked pin is ignored
        wr(3'd1, 8'hFE);
        pin[8] = 1'b1;
        #0.1;
        chk("R3 wake masked", wake, 0);
        repeat (4) cyc();
        chk("R3 flag masked", flag, 0);
        pin[8] = 1'b0;
        repeat (4) cyc();
        chk("R3 flag masked fall", flag, 0);
        wr(3'd1, 8'hFF);

        // R8 enable gating
        wr(3'd3, 8'h05);
        pin[9] = 1'b1;
        repeat (4) cyc();
        chk("R8 flag", flag, 3'b010);
        chk("R8 irq gated", irq, 3'b000);
        wr(3'd3, 8'h07);
        chk("R8 irq enabled", irq, 3'b010);
        wr(3'd4, 8'h07);

        // R6 partial clear and stickiness
        pin[0] = 1'b1; pin[16] = 1'b1;
        repeat (4) cyc();
        chk("R6 two flags", flag, 3'b101);
        wr(3'd4, 8'h01);
        chk("R6 partial clear", flag, 3'b100);
        repeat (6) cyc();
        chk("R6 sticky", flag, 3'b100);
        wr(3'd4, 8'h07);

        // R7 set beats clear in the same cycle
        pin[3] = 1'b1;
        cyc(); cyc();
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
        cyc();
        wr_en = 1'b0;
        chk("R7 set wins", flag, 3'b001);
        wr(3'd4, 8'h07);
        chk("R7 clear later", flag, 0);

        // R9 mask transitions
        wr(3'd0, 8'h00);
        repeat (4) cyc();
        wr(3'd4, 8'h07);
        pin[5] = 1'b0;
        wr(3'd0, 8'h20);
        repeat (4) cyc();
        chk("R9 unmask low", flag, 0);
        wr(3'd0, 8'h00);
        repeat (4) cyc();
        pin[5] = 1'b1;
        #0.1;
        chk("R9 masked high no wake", wake, 0);
        repeat (4) cyc();
        chk("R9 masked high no flag", flag, 0);
        wr(3'd0, 8'h20);
        repeat (4) cyc();
        chk("R9 unmask high", flag, 3'b001);
        wr(3'd4, 8'h07);
        wr(3'd0, 8'h00);
        repeat (4) cyc();
        chk("R9 mask high", flag, 3'b001);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule